// File: doc/BRIEF.md
# Fracturable Dual-Output Lookup Cell

This block is a configurable logic cell. It holds one 64-bit truth table and has eight logic inputs. It drives two combinational outputs. A 3-bit mode field decides how the table and the inputs are divided between the two outputs. The table can act as one 6-input function. It can also act as two smaller functions that may share some inputs. A further mode forms a 7-input function by choosing between two 5-input functions.

The table is loaded serially before the cell is used. While a load enable is high, one bit enters per clock. Once the enable drops, the table is frozen, and the outputs follow the inputs and the mode with no clock delay. Both outputs are forced low while a load is in progress.

Top module: `lut_frac_cell`

## Requirements
- R1: After reset the table T is all zeros, so both outputs are 0 in every mode and for every input value.
- R2: On each clock edge while `cfg_load_en` is 1, every table bit T[k] takes the value of T[k+1], and T[63] takes `cfg_bit`. After 64 load cycles, the first bit shifted in sits at T[0] and the last bit sits at T[63].
- R3: While `cfg_load_en` is 1, `y0` and `y1` are both 0 regardless of mode, inputs or table contents.
- R4: While `cfg_load_en` is 0, the table does not change, whatever `cfg_bit` does.
- R5: With mode code 0 (single 6-input), `y0 = T[din[5:0]]` and `y1 = y0`; `din[7:6]` have no effect.
- R6: With mode code 1 (two 5-input functions sharing din[1:0]), `y0 = T[{1'b0,din[4:0]}]` and `y1 = T[{1'b1,din[7:5],din[1:0]}]`.
- R7: With mode code 2 (5-input plus 4-input sharing din[0]), `y0 = T[{1'b0,din[4:0]}]` and `y1 = T[{2'b10,din[7:5],din[0]}]`.
- R8: With mode code 3 (5-input plus independent 3-input), `y0 = T[{1'b0,din[4:0]}]` and `y1 = T[{3'b100,din[7:5]}]`.
- R9: With mode code 4 (two independent 4-input functions), `y0 = T[{2'b00,din[3:0]}]` and `y1 = T[{2'b10,din[7:4]}]`.
- R10: With mode code 5 (extended 7-input), `y0 = din[6] ? T[{1'b1,din[5],din[3:0]}] : T[{1'b0,din[4],din[3:0]}]`, `din[7]` has no effect, and `y1 = y0`.
- R11: Mode codes 6 and 7 force both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the table loading |
| rst_n | input | 1 | Active-low asynchronous reset, clears the table |
| cfg_load_en | input | 1 | Shift enable for the serial table load |
| cfg_bit | input | 1 | Serial table data, entering at T[63] |
| cfg_mode | input | 3 | Split mode code |
| din | input | 8 | Logic inputs |
| y0 | output | 1 | First function output |
| y1 | output | 1 | Second function output |

## Verification
Tables of all zeros and all ones only show whether the outputs are gated. A table with a single 1 at the bottom, and then one with a single 1 at the top, shows the loading order and which end of the index is the LSB. The main table is irregular, so every table bit differs from its neighbours in at least some places. The vectors run it through all six modes. They set the shared, unused and select inputs separately, so a swapped input position or a wrong slice base gives a different output. Undefined codes, a change of `cfg_bit` while not loading, and a reload over a live table test the gating and hold paths.

// File: rtl/lut_frac_pkg.sv
package lut_frac_pkg;

  localparam int TBL_BITS = 64;
  localparam int ADDR_W   = $clog2(TBL_BITS);
  localparam int N_DIN    = 8;

  typedef enum logic [2:0] {
    SPLIT_SINGLE6 = 3'd0,
    SPLIT_SHARE2  = 3'd1,
    SPLIT_SHARE1  = 3'd2,
    SPLIT_FIVE3   = 3'd3,
    SPLIT_FOUR4   = 3'd4,
    SPLIT_EXT7    = 3'd5
  } split_mode_e;

  function automatic logic mode_known(input logic [2:0] m);
    return (m <= 3'd5);
  endfunction

  // Table address read by the lower half-function.
  function automatic logic [ADDR_W-1:0] addr_lo(input logic [2:0] m, input logic [N_DIN-1:0] d);
    logic [ADDR_W-1:0] a;
    case (m)
      SPLIT_SINGLE6: a = d[5:0];
      SPLIT_SHARE2,
      SPLIT_SHARE1,
      SPLIT_FIVE3,
      SPLIT_EXT7:    a = {1'b0, d[4:0]};
      SPLIT_FOUR4:   a = {2'b00, d[3:0]};
      default:       a = '0;
    endcase
    return a;
  endfunction

  // Table address read by the upper half-function (slice base 32).
  function automatic logic [ADDR_W-1:0] addr_hi(input logic [2:0] m, input logic [N_DIN-1:0] d);
    logic [ADDR_W-1:0] a;
    case (m)
      SPLIT_SHARE2: a = {1'b1, d[7:5], d[1:0]};
      SPLIT_SHARE1: a = {2'b10, d[7:5], d[0]};
      SPLIT_FIVE3:  a = {3'b100, d[7:5]};
      SPLIT_FOUR4:  a = {2'b10, d[7:4]};
      SPLIT_EXT7:   a = {1'b1, d[5], d[3:0]};
      default:      a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/lut_cfg_shreg.sv
module lut_cfg_shreg #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             shift_in,
  output logic [WIDTH-1:0] bits_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bits_q <= '0;
    else if (shift_en)
      bits_q <= {shift_in, bits_q[WIDTH-1:1]};
  end
endmodule

// File: rtl/lut_half_read.sv
module lut_half_read
  import lut_frac_pkg::*;
#(
  parameter bit UPPER = 1'b0
) (
  input  logic [TBL_BITS-1:0] tbl,
  input  logic [2:0]          mode,
  input  logic [N_DIN-1:0]    din,
  output logic [ADDR_W-1:0]   addr,
  output logic                bit_out
);
  generate
    if (UPPER) begin : g_hi
      assign addr = addr_hi(mode, din);
    end else begin : g_lo
      assign addr = addr_lo(mode, din);
    end
  endgenerate

  assign bit_out = tbl[addr];
endmodule

// File: rtl/lut_out_mux.sv
module lut_out_mux
  import lut_frac_pkg::*;
(
  input  logic       mode_ok,
  input  logic       loading,
  input  logic [2:0] mode,
  input  logic       ext_sel,
  input  logic       bit_a,
  input  logic       bit_b,
  output logic       y0,
  output logic       y1
);
  logic gate;
  assign gate = mode_ok && !loading;

  always_comb begin
    y0 = 1'b0;
    y1 = 1'b0;
    if (gate) begin
      case (mode)
        SPLIT_SINGLE6: begin
          y0 = bit_a;
          y1 = bit_a;
        end
        SPLIT_EXT7: begin
          y0 = ext_sel ? bit_b : bit_a;
          y1 = y0;
        end
        default: begin
          y0 = bit_a;
          y1 = bit_b;
        end
      endcase
    end
  end
endmodule

// File: rtl/lut_frac_cell.sv
module lut_frac_cell
  import lut_frac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_load_en,
  input  logic       cfg_bit,
  input  logic [2:0] cfg_mode,
  input  logic [7:0] din,
  output logic       y0,
  output logic       y1
);
  logic [TBL_BITS-1:0] cfg_q;
  logic [ADDR_W-1:0]   addr_a, addr_b;
  logic                bit_a, bit_b;
  logic                mode_ok;

  assign mode_ok = mode_known(cfg_mode);

  lut_cfg_shreg #(.WIDTH(TBL_BITS)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_load_en),
    .shift_in (cfg_bit),
    .bits_q   (cfg_q)
  );

  lut_half_read #(.UPPER(1'b0)) u_rd_a (
    .tbl     (cfg_q),
    .mode    (cfg_mode),
    .din     (din),
    .addr    (addr_a),
    .bit_out (bit_a)
  );

  lut_half_read #(.UPPER(1'b1)) u_rd_b (
    .tbl     (cfg_q),
    .mode    (cfg_mode),
    .din     (din),
    .addr    (addr_b),
    .bit_out (bit_b)
  );

  lut_out_mux u_mux (
    .mode_ok (mode_ok),
    .loading (cfg_load_en),
    .mode    (cfg_mode),
    .ext_sel (din[6]),
    .bit_a   (bit_a),
    .bit_b   (bit_b),
    .y0      (y0),
    .y1      (y1)
  );
endmodule

// File: rtl/lut_frac_checker.sv
module lut_frac_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_load_en,
  input logic        cfg_bit,
  input logic [2:0]  cfg_mode,
  input logic [7:0]  din,
  input logic        y0,
  input logic        y1,
  input logic [63:0] cfg_q,
  input logic        bit_a,
  input logic        bit_b
);
  // R2: shift direction and entry point
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load_en |=> (cfg_q[62:0] == $past(cfg_q[63:1])) && (cfg_q[63] == $past(cfg_bit)));

  // R3: outputs quiet while loading
  a_r3_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load_en |-> (!y0 && !y1));

  // R4: table frozen when not loading
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load_en |=> $stable(cfg_q));

  // R5: single mode mirrors and follows the lower read
  a_r5_single_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load_en && cfg_mode == 3'd0) |-> (y1 == y0) && (y0 == bit_a));

  // R10: extended mode mirrors and picks by din[6]
  a_r10_ext_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load_en && cfg_mode == 3'd5) |-> (y1 == y0) && (y0 == (din[6] ? bit_b : bit_a)));

  // R11: undefined codes silence both outputs
  a_r11_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode > 3'd5) |-> (!y0 && !y1));
endmodule

bind lut_frac_cell lut_frac_checker u_lut_frac_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_load_en (cfg_load_en),
  .cfg_bit     (cfg_bit),
  .cfg_mode    (cfg_mode),
  .din         (din),
  .y0          (y0),
  .y1          (y1),
  .cfg_q       (cfg_q),
  .bit_a       (bit_a),
  .bit_b       (bit_b)
);

// File: tb/test_lut_frac_cell.sv
module test_lut_frac_cell;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load_en = 1'b0;
  logic       cfg_bit = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic [7:0] din = 8'd0;
  logic       y0, y1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [63:0] T_MAIN = 64'h9C3E_51A7_0F6D_B428;

  // {mode, din}
  localparam logic [10:0] VEC [28] = '{
    {3'd0, 8'h00}, {3'd0, 8'h2B}, {3'd0, 8'hC5}, {3'd0, 8'h3F}, {3'd0, 8'h17},
    {3'd1, 8'h00}, {3'd1, 8'hE3}, {3'd1, 8'h1C}, {3'd1, 8'hA2}, {3'd1, 8'h5D},
    {3'd2, 8'hE1}, {3'd2, 8'h1E}, {3'd2, 8'h61}, {3'd2, 8'hB7},
    {3'd3, 8'hE0}, {3'd3, 8'h1F}, {3'd3, 8'h4A}, {3'd3, 8'hA9},
    {3'd4, 8'hF0}, {3'd4, 8'h0F}, {3'd4, 8'h96}, {3'd4, 8'h3C},
    {3'd5, 8'h1F}, {3'd5, 8'h5F}, {3'd5, 8'h60}, {3'd5, 8'hAB}, {3'd5, 8'hC4},
    {3'd5, 8'h2E}
  };

  lut_frac_cell i_lut_frac_cell (
    .clk(clk), .rst_n(rst_n), .cfg_load_en(cfg_load_en), .cfg_bit(cfg_bit),
    .cfg_mode(cfg_mode), .din(din), .y0(y0), .y1(y1)
  );

  always #4 clk = ~clk;

  // Independent model: build each index from a list of input positions.
  function automatic logic [1:0] model(input logic [63:0] t, input logic [2:0] m, input logic [7:0] d);
    int pa [6];
    int pb [6];
    int base_b;
    int ia, ib;
    logic ra, rb;
    for (int k = 0; k < 6; k++) begin pa[k] = -1; pb[k] = -1; end
    base_b = 32;
    case (m)
      3'd0: for (int k = 0; k < 6; k++) pa[k] = k;
      3'd1: begin
        for (int k = 0; k < 5; k++) pa[k] = k;
        pb[0] = 0; pb[1] = 1; pb[2] = 5; pb[3] = 6; pb[4] = 7;
      end
      3'd2: begin
        for (int k = 0; k < 5; k++) pa[k] = k;
        pb[0] = 0; pb[1] = 5; pb[2] = 6; pb[3] = 7;
      end
      3'd3: begin
        for (int k = 0; k < 5; k++) pa[k] = k;
        pb[0] = 5; pb[1] = 6; pb[2] = 7;
      end
      3'd4: for (int k = 0; k < 4; k++) begin pa[k] = k; pb[k] = k + 4; end
      3'd5: begin
        for (int k = 0; k < 4; k++) begin pa[k] = k; pb[k] = k; end
        pa[4] = 4; pb[4] = 5;
      end
      default: return 2'b00;
    endcase
    ia = 0; ib = base_b;
    for (int k = 0; k < 6; k++) begin
      if (pa[k] >= 0 && d[pa[k]]) ia += (1 << k);
      if (pb[k] >= 0 && d[pb[k]]) ib += (1 << k);
    end
    ra = t[ia];
    rb = t[ib];
    if (m == 3'd0) return {ra, ra};
    if (m == 3'd5) return d[6] ? {rb, rb} : {ra, ra};
    return {rb, ra};
  endfunction

  task automatic check(input string req, input logic [1:0] exp);
    n_chk++;
    if ({y1, y0} !== exp) begin
      n_bad++;
      $display("FAIL %s mode=%0d din=%h: got y1y0=%b expected %b", req, cfg_mode, din, {y1, y0}, exp);
    end
  endtask

  task automatic apply(input logic [2:0] m, input logic [7:0] d);
    @(negedge clk);
    cfg_mode = m;
    din = d;
    #1;
  endtask

  task automatic load_tbl(input logic [63:0] v, input bit probe);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      cfg_load_en = 1'b1;
      cfg_bit = v[i];
      if (probe && (i == 0 || i == 40)) begin
        #1;
        check("R3", 2'b00);
      end
    end
    @(negedge clk);
    cfg_load_en = 1'b0;
    cfg_bit = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: cleared table in every defined mode
    for (int m = 0; m < 6; m++) begin
      apply(3'(m), 8'hFF);
      check("R1", 2'b00);
      apply(3'(m), 8'h5A);
      check("R1", 2'b00);
    end

    // All-ones table
    load_tbl({64{1'b1}}, 1'b0);
    apply(3'd0, 8'h2D); check("R2", 2'b11);
    apply(3'd4, 8'h81); check("R9", 2'b11);
    // R11: undefined codes with a live table
    apply(3'd6, 8'h2D); check("R11", 2'b00);
    apply(3'd7, 8'hFF); check("R11", 2'b00);

    // R2: first bit in lands at T[0]; R3 probed over a table of ones
    load_tbl(64'h1, 1'b1);
    apply(3'd0, 8'h00); check("R2", 2'b11);
    apply(3'd0, 8'h01); check("R2", 2'b00);
    apply(3'd0, 8'h3F); check("R2", 2'b00);
    apply(3'd0, 8'hC0); check("R5", 2'b11);

    // R2: last bit in lands at T[63]
    load_tbl(64'h8000_0000_0000_0000, 1'b0);
    apply(3'd0, 8'h3F); check("R2", 2'b11);
    apply(3'd0, 8'h3E); check("R2", 2'b00);
    apply(3'd1, 8'hE3); check("R6", 2'b10);

    // Main table, vector walk
    load_tbl(T_MAIN, 1'b1);
    foreach (VEC[i]) begin
      apply(VEC[i][10:8], VEC[i][7:0]);
      case (VEC[i][10:8])
        3'd0: check("R5", model(T_MAIN, VEC[i][10:8], VEC[i][7:0]));
        3'd1: check("R6", model(T_MAIN, VEC[i][10:8], VEC[i][7:0]));
        3'd2: check("R7", model(T_MAIN, VEC[i][10:8], VEC[i][7:0]));
        3'd3: check("R8", model(T_MAIN, VEC[i][10:8], VEC[i][7:0]));
        3'd4: check("R9", model(T_MAIN, VEC[i][10:8], VEC[i][7:0]));
        default: check("R10", model(T_MAIN, VEC[i][10:8], VEC[i][7:0]));
      endcase
    end

    // R5: din[7:6] ignored; R10: din[7] ignored
    apply(3'd0, 8'h15); check("R5", model(T_MAIN, 3'd0, 8'h15));
    apply(3'd0, 8'hD5); check("R5", model(T_MAIN, 3'd0, 8'h15));
    apply(3'd5, 8'h4B); check("R10", model(T_MAIN, 3'd5, 8'h4B));
    apply(3'd5, 8'hCB); check("R10", model(T_MAIN, 3'd5, 8'h4B));

    // R4: cfg_bit toggling without enable leaves the table intact
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cfg_bit = ~cfg_bit;
    end
    cfg_bit = 1'b0;
    for (int d = 0; d < 64; d += 7) begin
      apply(3'd0, 8'(d));
      check("R4", model(T_MAIN, 3'd0, 8'(d)));
    end

    // R11: undefined codes with the main table
    apply(3'd6, 8'h00); check("R11", 2'b00);
    apply(3'd7, 8'h3C); check("R11", 2'b00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule